// File: doc/BRIEF.md
# Dual-Phase Serial Frame Transmitter

This block sends audio or data words one bit at a time on a serial line. Each frame starts with a frame sync pulse. A frame is made of one phase or of two phases back to back. Each phase has its own word length and its own number of words. Bit clock and frame sync arrive from outside the system clock domain. The block resamples them and then chooses the active bit clock edge according to a polarity setting. A programmable delay of zero, one or two bit slots sits between the frame sync and the first data bit.

A host or DMA engine writes words into a 32-bit holding register. At the start of each word slot the holding register is copied into the shifter, and a ready flag asks for the next word. If no new word arrives in time, the old word is sent again. When a frame sync arrives in the middle of a frame, the block does one of two things, selected by a setting:

- it restarts the frame and latches a sticky error flag, or
- it ignores the pulse.

Dropping the enable input holds the engine idle and clears the error flag. After the enable is raised again, the engine only accepts frames once it has seen bit clock transitions.

Top module: `serial_frame_tx`

## Requirements
- R1: The 3-bit length code of each phase selects 8, 12, 16, 20, 24 or 32 bits for codes 0 to 5. Codes 6 and 7 also select 32. A word is sent MSB first, starting at holding bit (length-1). Holding bits at or above the length are never sent.
- R2: The per-phase word field holds the word count minus one, so 0 sends one word. Consecutive words follow in consecutive bit slots with no gap.
- R3: When `two_phase` is 1, the second phase follows the last bit of the first phase in the next slot. The second phase uses `ph1_len` and `ph1_words`. When `two_phase` is 0, the frame ends after the first phase.
- R4: `data_delay` sets when the first data bit is driven, counted in active edges from the edge at which the frame sync is seen:
  - 0: on that same edge.
  - 1: on the next active edge.
  - 2: on the second active edge after it.
  - 3: behaves as 2.

  `sdata` is low during the delay and between frames.
- R5: When `clk_pol` is 0, data changes and frame sync is sampled on rising `bclk` edges. When `clk_pol` is 1, both happen on falling edges. `bclk` and `fsync` pass through a two-flop resampler, so `sdata` changes on the third system clock edge after the `bclk` change.
- R6: With `fs_ignore` at 0, a frame sync seen while delay slots or data bits of the current frame remain does two things: it sets `sync_err`, and it restarts the frame from word one of the first phase. A frame sync on the slot right after the final bit is not an error.
- R7: With `fs_ignore` at 1, a frame sync in the middle of a frame has no effect: the bits continue unchanged and `sync_err` stays low.
- R8: While `tx_en` is 0, `sdata`, `tx_ready` and `sync_err` are 0. After `tx_en` rises, frame syncs are ignored until two `bclk` transitions have been seen.
- R9: `tx_ready` rises one clock after the holding register is copied into the shifter. A write to the holding register clears it one clock later. A write wins over a copy in the same cycle.
- R10: If the holding register is not written before the next word slot, the same word is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable; low holds the engine in reset |
| two_phase | input | 1 | Enable the second phase |
| ph0_len | input | 3 | First phase word length code |
| ph0_words | input | 7 | First phase word count minus one |
| ph1_len | input | 3 | Second phase word length code |
| ph1_words | input | 7 | Second phase word count minus one |
| data_delay | input | 2 | Bit slots between frame sync and first bit |
| fs_ignore | input | 1 | Ignore frame syncs in the middle of a frame |
| clk_pol | input | 1 | 0: active edge rising, 1: active edge falling |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_data | input | 32 | Holding register write data |
| bclk | input | 1 | Bit clock |
| fsync | input | 1 | Frame sync, active high |
| sdata | output | 1 | Serial data out |
| tx_ready | output | 1 | Holding register copied; ready for a new word |
| sync_err | output | 1 | Sticky unexpected frame sync flag |

## Verification
The hardest cases to reach are a frame sync that lands inside a running frame and a frame sync that lands during the wake-up window after enable. Neither can be seen from the ports unless the bit stream around it is predicted exactly. The stimulus generates the bit clock slot by slot. Frame syncs are placed at chosen slot indices: some before the first two bit clock transitions, some partway through a 32-bit word. The scenario is repeated with the ignore setting on and off. A behavioural model keeps a queue of pending bit slots and is compared with `sdata`, `tx_ready` and `sync_err` on every clock. The queue makes it plain whether a given pulse should restart the frame.

// File: rtl/sft_pkg.sv
package sft_pkg;

    localparam int HOLD_W = 32;
    localparam int LEN_W  = 6;
    localparam int CNT_W  = 7;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAKE,
        ST_IDLE,
        ST_DELAY,
        ST_SHIFT
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_HOLD,
        CMD_ZERO,
        CMD_LOAD,
        CMD_SHIFT
    } shift_cmd_e;

    typedef struct packed {
        logic [2:0]       len_code;
        logic [CNT_W-1:0] words_m1;
    } phase_cfg_t;

    typedef struct packed {
        phase_cfg_t ph0;
        phase_cfg_t ph1;
        logic       two_phase;
        logic [1:0] delay;
        logic       fs_ignore;
    } frame_cfg_t;

    function automatic logic [LEN_W-1:0] code_to_len(input logic [2:0] code);
        case (code)
            3'd0:    return LEN_W'(8);
            3'd1:    return LEN_W'(12);
            3'd2:    return LEN_W'(16);
            3'd3:    return LEN_W'(20);
            3'd4:    return LEN_W'(24);
            default: return LEN_W'(32);
        endcase
    endfunction

endpackage

// File: rtl/sft_edge_sync.sv
module sft_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bclk,
    input  logic fsync,
    input  logic fall_edge,
    output logic tick,
    output logic any_edge,
    output logic fs_s
);
    logic [STAGES-1:0] b_pipe;
    logic [STAGES-1:0] f_pipe;
    logic              b_prev;
    logic              b_now;
    logic              rise;
    logic              fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            b_pipe <= '0;
            f_pipe <= '0;
            b_prev <= 1'b0;
        end else begin
            b_pipe <= {b_pipe[STAGES-2:0], bclk};
            f_pipe <= {f_pipe[STAGES-2:0], fsync};
            b_prev <= b_pipe[STAGES-1];
        end
    end

    assign b_now    = b_pipe[STAGES-1];
    assign rise     = b_now & ~b_prev;
    assign fall     = ~b_now & b_prev;
    assign tick     = fall_edge ? fall : rise;
    assign any_edge = rise | fall;
    assign fs_s     = f_pipe[STAGES-1];

endmodule

// File: rtl/sft_frame_seq.sv
module sft_frame_seq
    import sft_pkg::*;
#(
    parameter int WAKE_EDGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_en,
    input  logic             tick,
    input  logic             any_edge,
    input  logic             fs_s,
    input  frame_cfg_t       cfg,
    output shift_cmd_e       cmd,
    output logic [LEN_W-1:0] load_len,
    output logic             sync_err
);
    localparam int WAKE_W = $clog2(WAKE_EDGES + 1);

    seq_state_e        st_q, st_n;
    logic [WAKE_W-1:0] wake_q, wake_n;
    logic              wait_q, wait_n;
    logic [LEN_W-1:0]  bits_q, bits_n;
    logic [CNT_W-1:0]  words_q, words_n;
    logic              phase_q, phase_n;
    logic              err_q, err_n;
    logic [1:0]        eff_delay;
    logic [LEN_W-1:0]  len0, len1, len_cur;
    logic              start_frame;
    logic              last_phase;

    assign eff_delay   = (cfg.delay == 2'd3) ? 2'd2 : cfg.delay;
    assign len0        = code_to_len(cfg.ph0.len_code);
    assign len1        = code_to_len(cfg.ph1.len_code);
    assign len_cur     = phase_q ? len1 : len0;
    assign last_phase  = phase_q | ~cfg.two_phase;
    assign start_frame = fs_s && (st_q == ST_IDLE || !cfg.fs_ignore);

    always_comb begin
        st_n     = st_q;
        wake_n   = wake_q;
        wait_n   = wait_q;
        bits_n   = bits_q;
        words_n  = words_q;
        phase_n  = phase_q;
        err_n    = err_q;
        cmd      = CMD_HOLD;
        load_len = len0;
        if (!tx_en) begin
            st_n   = ST_OFF;
            err_n  = 1'b0;
            wake_n = '0;
        end else begin
            case (st_q)
                ST_OFF: begin
                    st_n   = ST_WAKE;
                    wake_n = '0;
                end
                ST_WAKE: begin
                    if (any_edge) begin
                        if (wake_q == WAKE_W'(WAKE_EDGES - 1)) st_n = ST_IDLE;
                        else wake_n = wake_q + 1'b1;
                    end
                end
                default: begin
                    if (tick) begin
                        if (start_frame) begin
                            if (st_q != ST_IDLE) err_n = 1'b1;
                            phase_n = 1'b0;
                            words_n = cfg.ph0.words_m1;
                            if (eff_delay == 2'd0) begin
                                cmd      = CMD_LOAD;
                                load_len = len0;
                                bits_n   = len0 - 1'b1;
                                st_n     = ST_SHIFT;
                            end else begin
                                cmd    = CMD_ZERO;
                                wait_n = 1'(eff_delay - 2'd1);
                                st_n   = ST_DELAY;
                            end
                        end else begin
                            case (st_q)
                                ST_IDLE: cmd = CMD_ZERO;
                                ST_DELAY: begin
                                    if (!wait_q) begin
                                        cmd      = CMD_LOAD;
                                        load_len = len0;
                                        bits_n   = len0 - 1'b1;
                                        st_n     = ST_SHIFT;
                                    end else begin
                                        wait_n = 1'b0;
                                    end
                                end
                                ST_SHIFT: begin
                                    if (bits_q != '0) begin
                                        cmd    = CMD_SHIFT;
                                        bits_n = bits_q - 1'b1;
                                        if (bits_q == LEN_W'(1) && words_q == '0 && last_phase)
                                            st_n = ST_IDLE;
                                    end else if (words_q != '0) begin
                                        cmd      = CMD_LOAD;
                                        load_len = len_cur;
                                        words_n  = words_q - 1'b1;
                                        bits_n   = len_cur - 1'b1;
                                    end else begin
                                        cmd      = CMD_LOAD;
                                        load_len = len1;
                                        phase_n  = 1'b1;
                                        words_n  = cfg.ph1.words_m1;
                                        bits_n   = len1 - 1'b1;
                                    end
                                end
                                default: ;
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_OFF;
            wake_q  <= '0;
            wait_q  <= 1'b0;
            bits_q  <= '0;
            words_q <= '0;
            phase_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            st_q    <= st_n;
            wake_q  <= wake_n;
            wait_q  <= wait_n;
            bits_q  <= bits_n;
            words_q <= words_n;
            phase_q <= phase_n;
            err_q   <= err_n;
        end
    end

    assign sync_err = err_q;

    // R6: the error flag only rises after a sampled frame sync on an active edge
    assert_err_needs_sync_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_err) |-> $past(fs_s && tick));

    // R7: with ignore set the flag never rises
    assert_ignore_no_err_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg.fs_ignore && tx_en) |=> !$rose(sync_err));

    // R8: disable forces idle and clears the flag
    assert_off_clears_R8: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (!sync_err && st_q == ST_OFF));

    // R8: wake-up cannot complete without a bit clock transition
    assert_wake_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAKE && tx_en && !any_edge) |=> st_q == ST_WAKE);

endmodule

// File: rtl/sft_shifter.sv
module sft_shifter
    import sft_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              hold_wr,
    input  logic [HOLD_W-1:0] hold_data,
    input  shift_cmd_e        cmd,
    input  logic [LEN_W-1:0]  load_len,
    output logic              sdata,
    output logic              tx_ready
);
    logic [HOLD_W-1:0] hold_q;
    logic [HOLD_W-1:0] shreg;
    logic [HOLD_W-1:0] aligned;
    logic [LEN_W-1:0]  pad;

    assign pad     = LEN_W'(HOLD_W) - load_len;
    assign aligned = hold_q << pad;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            shreg    <= '0;
            sdata    <= 1'b0;
            tx_ready <= 1'b0;
        end else begin
            if (hold_wr) hold_q <= hold_data;
            if (!enable) begin
                sdata    <= 1'b0;
                tx_ready <= 1'b0;
            end else begin
                case (cmd)
                    CMD_ZERO: sdata <= 1'b0;
                    CMD_LOAD: begin
                        shreg <= aligned;
                        sdata <= aligned[HOLD_W-1];
                    end
                    CMD_SHIFT: begin
                        sdata <= shreg[HOLD_W-2];
                        shreg <= shreg << 1;
                    end
                    default: ;
                endcase
                if (hold_wr) tx_ready <= 1'b0;
                else if (cmd == CMD_LOAD) tx_ready <= 1'b1;
            end
        end
    end

    // R9: a copy without a competing write raises ready
    assert_load_sets_ready_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD && enable && !hold_wr) |=> tx_ready);

    // R9: a write always drops ready
    assert_write_clears_ready_R9: assert property (@(posedge clk) disable iff (rst)
        hold_wr |=> !tx_ready);

    // R4: a zero slot drives the line low
    assert_zero_slot_low_R4: assert property (@(posedge clk) disable iff (rst)
        (enable && cmd == CMD_ZERO) |=> !sdata);

    // R8: disabled engine keeps the line low
    assert_disabled_low_R8: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!sdata && !tx_ready));

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import sft_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_EDGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              two_phase,
    input  logic [2:0]        ph0_len,
    input  logic [CNT_W-1:0]  ph0_words,
    input  logic [2:0]        ph1_len,
    input  logic [CNT_W-1:0]  ph1_words,
    input  logic [1:0]        data_delay,
    input  logic              fs_ignore,
    input  logic              clk_pol,
    input  logic              hold_wr,
    input  logic [HOLD_W-1:0] hold_data,
    input  logic              bclk,
    input  logic              fsync,
    output logic              sdata,
    output logic              tx_ready,
    output logic              sync_err
);
    frame_cfg_t       cfg;
    logic             tick;
    logic             any_edge;
    logic             fs_s;
    shift_cmd_e       cmd;
    logic [LEN_W-1:0] load_len;

    assign cfg.ph0.len_code = ph0_len;
    assign cfg.ph0.words_m1 = ph0_words;
    assign cfg.ph1.len_code = ph1_len;
    assign cfg.ph1.words_m1 = ph1_words;
    assign cfg.two_phase    = two_phase;
    assign cfg.delay        = data_delay;
    assign cfg.fs_ignore    = fs_ignore;

    sft_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .bclk      (bclk),
        .fsync     (fsync),
        .fall_edge (clk_pol),
        .tick      (tick),
        .any_edge  (any_edge),
        .fs_s      (fs_s)
    );

    sft_frame_seq #(.WAKE_EDGES(WAKE_EDGES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .tx_en    (tx_en),
        .tick     (tick),
        .any_edge (any_edge),
        .fs_s     (fs_s),
        .cfg      (cfg),
        .cmd      (cmd),
        .load_len (load_len),
        .sync_err (sync_err)
    );

    sft_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .enable    (tx_en),
        .hold_wr   (hold_wr),
        .hold_data (hold_data),
        .cmd       (cmd),
        .load_len  (load_len),
        .sdata     (sdata),
        .tx_ready  (tx_ready)
    );

endmodule

// File: tb/serial_frame_tx_tb.sv
module serial_frame_tx_tb;

    localparam int H = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_en = 1'b0;
    logic        two_phase = 1'b0;
    logic [2:0]  ph0_len = 3'd0;
    logic [6:0]  ph0_words = 7'd0;
    logic [2:0]  ph1_len = 3'd0;
    logic [6:0]  ph1_words = 7'd0;
    logic [1:0]  data_delay = 2'd0;
    logic        fs_ignore = 1'b0;
    logic        clk_pol = 1'b0;
    logic        hold_wr = 1'b0;
    logic [31:0] hold_data = 32'd0;
    logic        bclk = 1'b0;
    logic        fsync = 1'b0;
    logic        sdata, tx_ready, sync_err;

    always #5 clk = ~clk;

    serial_frame_tx u_dut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .two_phase(two_phase),
        .ph0_len(ph0_len), .ph0_words(ph0_words), .ph1_len(ph1_len),
        .ph1_words(ph1_words), .data_delay(data_delay), .fs_ignore(fs_ignore),
        .clk_pol(clk_pol), .hold_wr(hold_wr), .hold_data(hold_data),
        .bclk(bclk), .fsync(fsync), .sdata(sdata), .tx_ready(tx_ready),
        .sync_err(sync_err)
    );

    int    tests = 0;
    int    fails = 0;
    string tag = "R8";
    bit    feed = 1'b0;
    int    wr_n = 1;
    bit    done = 1'b0;

    // ---------------- reference model ----------------
    logic [31:0] m_hold, m_word;
    logic        m_sdata, m_ready, m_err;
    int          m_mode, m_wake, m_pos, m_d, m_e;
    int          m_q[$];
    logic        hb[3];
    logic        hf[3];
    logic        m_tick, m_edge, m_fs, m_load;

    function automatic int len_of(input int code);
        case (code)
            0: return 8;
            1: return 12;
            2: return 16;
            3: return 20;
            4: return 24;
            default: return 32;
        endcase
    endfunction

    task automatic push_phase(input int code, input int words_m1);
        int l;
        l = len_of(code);
        for (int w = 0; w <= words_m1; w++) begin
            m_q.push_back(l);
            for (int b = 1; b < l; b++) m_q.push_back(0);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_hold = '0; m_word = '0; m_sdata = 0; m_ready = 0; m_err = 0;
            m_mode = 0; m_wake = 0; m_pos = 0; m_q.delete();
            for (int i = 0; i < 3; i++) begin hb[i] = 0; hf[i] = 0; end
        end else begin
            m_edge = hb[1] != hb[2];
            m_tick = clk_pol ? (hb[2] && !hb[1]) : (!hb[2] && hb[1]);
            m_fs   = hf[1];
            m_load = 0;
            if (!tx_en) begin
                m_mode = 0; m_err = 0; m_sdata = 0; m_q.delete();
            end else if (m_mode == 0) begin
                m_mode = 1; m_wake = 0;
            end else if (m_mode == 1) begin
                if (m_edge) begin
                    m_wake++;
                    if (m_wake == 2) m_mode = 2;
                end
            end else if (m_tick) begin
                if (m_fs && (m_q.size() == 0 || !fs_ignore)) begin
                    if (m_q.size() != 0) m_err = 1;
                    m_q.delete();
                    m_d = (data_delay == 2'd3) ? 2 : int'(data_delay);
                    repeat (m_d) m_q.push_back(-1);
                    push_phase(int'(ph0_len), int'(ph0_words));
                    if (two_phase) push_phase(int'(ph1_len), int'(ph1_words));
                end
                if (m_q.size() == 0) m_sdata = 0;
                else begin
                    m_e = m_q.pop_front();
                    if (m_e < 0) m_sdata = 0;
                    else if (m_e > 0) begin
                        m_word = m_hold; m_pos = m_e - 1; m_sdata = m_word[m_pos]; m_load = 1;
                    end else begin
                        m_pos--; m_sdata = m_word[m_pos];
                    end
                end
            end
            if (!tx_en) m_ready = 0;
            else if (hold_wr) m_ready = 0;
            else if (m_load) m_ready = 1;
            if (hold_wr) m_hold = hold_data;
            hb[2] = hb[1]; hb[1] = hb[0]; hb[0] = bclk;
            hf[2] = hf[1]; hf[1] = hf[0]; hf[0] = fsync;
        end
    end

    task automatic check(input string req, input string what, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            tests++;
            if (sdata !== m_sdata || tx_ready !== m_ready || sync_err !== m_err) begin
                fails++;
                $display("FAIL %s cycle compare actual=%0b%0b%0b expected=%0b%0b%0b at %0t",
                         tag, sdata, tx_ready, sync_err, m_sdata, m_ready, m_err, $time);
            end
        end
    end

    // host writer: refills the holding register when ready is seen
    always @(negedge clk) begin
        if (hold_wr) begin
            hold_wr = 1'b0;
            check("R9", "ready after write", tx_ready, 1'b0);
        end else if (feed && tx_ready) begin
            hold_data = 32'h9E37_79B9 * wr_n + 32'h0F0F_1234;
            wr_n++;
            hold_wr = 1'b1;
        end
    end

    task automatic bit_slot(input logic fsv);
        @(negedge clk);
        bclk = 1'b0; fsync = fsv;
        repeat (H) @(negedge clk);
        bclk = 1'b1;
        repeat (H - 1) @(negedge clk);
    endtask

    task automatic frames(input int nf, input int period, input int extra);
        for (int f = 0; f < nf; f++)
            for (int b = 0; b < period; b++)
                bit_slot(b == 0 || b == extra);
    endtask

    task automatic disable_tx();
        tx_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic enable_tx();
        tx_en = 1'b1;
        repeat (3) bit_slot(1'b0);
    endtask

    task automatic summary();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8", "reset sdata", sdata, 1'b0);
        check("R8", "reset ready", tx_ready, 1'b0);
        check("R8", "reset err", sync_err, 1'b0);

        // R2: one phase of two 16-bit words, delay 1, rising edge
        tag = "R2"; feed = 1'b1;
        ph0_len = 3'd2; ph0_words = 7'd1; data_delay = 2'd1; clk_pol = 1'b0;
        enable_tx();
        frames(2, 40, -1);
        check("R2", "no error on regular frames", sync_err, 1'b0);

        // R3 / R5: two phases, 3x8 then 1x32, delay 0, falling edge
        tag = "R3/R5";
        disable_tx();
        two_phase = 1'b1; ph0_len = 3'd0; ph0_words = 7'd2;
        ph1_len = 3'd5; ph1_words = 7'd0; data_delay = 2'd0; clk_pol = 1'b1;
        enable_tx();
        frames(2, 60, -1);

        // R1 / R4: every length code, delays 2 and 3
        tag = "R1/R4";
        for (int c = 0; c < 8; c++) begin
            disable_tx();
            two_phase = 1'b0; clk_pol = 1'b0;
            ph0_len = 3'(c); ph0_words = 7'd0;
            data_delay = (c == 7) ? 2'd3 : 2'd2;
            enable_tx();
            frames(1, 36, -1);
        end

        // R8: frame sync during wake-up is ignored
        tag = "R8";
        disable_tx();
        check("R8", "disabled sdata", sdata, 1'b0);
        ph0_len = 3'd2; ph0_words = 7'd0; data_delay = 2'd1;
        tx_en = 1'b1;
        frames(1, 24, -1);
        check("R8", "no error after wake", sync_err, 1'b0);

        // R6: mid-frame sync restarts and flags
        tag = "R6";
        disable_tx();
        ph0_len = 3'd5; ph0_words = 7'd0; data_delay = 2'd1; fs_ignore = 1'b0;
        enable_tx();
        frames(1, 40, 15);
        check("R6", "error after mid-frame sync", sync_err, 1'b1);
        tx_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R8", "error cleared by disable", sync_err, 1'b0);

        // R7: mid-frame sync ignored
        tag = "R7";
        fs_ignore = 1'b1;
        enable_tx();
        frames(1, 40, 15);
        check("R7", "no error with ignore", sync_err, 1'b0);

        // R10: no host writes, words repeat
        tag = "R10";
        disable_tx();
        feed = 1'b0; fs_ignore = 1'b0;
        ph0_len = 3'd2; ph0_words = 7'd3; data_delay = 2'd1;
        enable_tx();
        frames(2, 70, -1);
        check("R10", "ready stays set without writes", tx_ready, 1'b1);

        repeat (4) @(negedge clk);
        summary();
    end

endmodule